// File: doc/BRIEF.md
# Packed Single-Precision NaN Resolver

This block sits beside a packed floating-point datapath. It works on two 128-bit operands, each carrying four IEEE single-precision lanes. For every lane it decides whether the arithmetic result has to be replaced, either by a propagated NaN or by the default quiet NaN. The arithmetic unit supplies one invalid-operation flag per lane. A mode input chooses between two-operand and one-operand instructions.

For each lane the block returns an override strobe, the 32-bit replacement value and an invalid-exception flag. A downstream mux uses the strobe to choose between the replacement and the arithmetic result. An optional output register stage captures all four lanes together under a valid handshake. That stage is on when the parameter `REG_OUT` is 1, which is the default.

Top module: `nanres_top`

## Requirements
- R1: Lane i occupies bits 32*i+31 down to 32*i of each operand and of `ovr_value`. In a lane, bits 30:23 are the exponent and bits 22:0 the fraction. A lane is a NaN when the exponent is all ones and the fraction is nonzero. Fraction bit 22 set means quiet and clear means signalling. An infinity (zero fraction) is not a NaN.
- R2: In two-operand mode, when both lanes are NaN of any kind, the result is the source-1 NaN, quieted if it is signalling. This holds even when only source 2 is signalling.
- R3: When exactly one lane is a signalling NaN and the other is a real value, the result is that NaN quieted. Quieting sets bit 22 and keeps the sign and every other bit.
- R4: When exactly one lane is a quiet NaN and the other is a real value, the result is that NaN unchanged.
- R5: In one-operand mode (`one_op`=1), only source 1 is examined. A signalling NaN is quieted, a quiet NaN passes through, and source 2 has no effect on any output.
- R6: When no examined input is a NaN and `dp_invalid` is set for the lane, the result is 32'hFFC00000.
- R7: `inv_flag` for a lane is 1 when any examined input is a signalling NaN or when `dp_invalid` is set. It is 0 when only quiet NaNs are propagated.
- R8: When no examined input is a NaN and `dp_invalid` is clear, `ovr_valid` is 0, `inv_flag` is 0 and the lane value is zero.
- R9: With `REG_OUT`=1, the outputs take the results for the inputs presented with `in_valid`=1, and `out_valid` is 1 on the following cycle. With `in_valid`=0, `out_valid` drops and the lane outputs hold. After reset, all outputs are zero.
- R10: Each lane is resolved from its own operand bits and its own `dp_invalid` bit only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and flags are valid this cycle |
| one_op | input | 1 | 1 selects one-operand mode (source 1 only) |
| src1 | input | 128 | Source 1, four packed lanes |
| src2 | input | 128 | Source 2, four packed lanes |
| dp_invalid | input | 4 | Per-lane invalid-operation flag from the datapath |
| out_valid | output | 1 | Result outputs carry a new result |
| ovr_valid | output | 4 | Per-lane override strobe |
| ovr_value | output | 128 | Per-lane replacement value |
| inv_flag | output | 4 | Per-lane invalid-exception flag |

## Verification
The bench checks a signalling NaN in source 2 against a quiet NaN in source 1. A design that picked the signalling operand, or the source-2 operand, would return the wrong payload. Quieting is checked with negative NaNs and with payloads that have many bits set, so a design that rebuilds the NaN instead of setting bit 22 would lose the sign or payload bits. Infinities sit next to NaNs to catch a classifier that tests only the exponent. In one-operand mode, source 2 carries signalling NaNs that must leave no trace. Quiet-only propagation is checked for a clear exception flag, and a held output is checked across idle cycles.

// File: rtl/nanres_pkg.sv
package nanres_pkg;
  localparam int LANE_W   = 32;
  localparam int EXP_MSB  = 30;
  localparam int EXP_LSB  = 23;
  localparam int QUIET_B  = 22;
  localparam int FRAC_W   = EXP_LSB;
  localparam logic [LANE_W-1:0] DEFAULT_QNAN = 32'hFFC0_0000;

  typedef struct packed {
    logic              ovr;
    logic              inv;
    logic [LANE_W-1:0] val;
  } lane_res_t;

  function automatic logic [LANE_W-1:0] make_quiet(input logic [LANE_W-1:0] x);
    logic [LANE_W-1:0] r;
    r = x;
    r[QUIET_B] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/nanres_classify.sv
module nanres_classify
  import nanres_pkg::*;
(
  input  logic [LANE_W-1:0] word,
  output logic              is_nan,
  output logic              is_snan
);
  logic exp_ones;
  logic frac_nz;

  always_comb begin
    exp_ones = &word[EXP_MSB:EXP_LSB];
    frac_nz  = |word[FRAC_W-1:0];
    is_nan   = exp_ones && frac_nz;
    is_snan  = is_nan && !word[QUIET_B];
  end
endmodule

// File: rtl/nanres_lane.sv
module nanres_lane
  import nanres_pkg::*;
(
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic              dp_inv,
  input  logic              one_op,
  output lane_res_t         res
);
  logic a_nan, a_snan, b_nan_raw, b_snan_raw;
  logic b_nan, b_snan;

  nanres_classify u_cls_a (.word(a), .is_nan(a_nan),     .is_snan(a_snan));
  nanres_classify u_cls_b (.word(b), .is_nan(b_nan_raw), .is_snan(b_snan_raw));

  always_comb begin
    b_nan  = b_nan_raw  && !one_op;
    b_snan = b_snan_raw && !one_op;
    res    = '0;
    if (a_nan) begin
      res.ovr = 1'b1;
      res.val = make_quiet(a);
    end else if (b_nan) begin
      res.ovr = 1'b1;
      res.val = make_quiet(b);
    end else if (dp_inv) begin
      res.ovr = 1'b1;
      res.val = DEFAULT_QNAN;
    end
    res.inv = a_snan || b_snan || dp_inv;
  end

  always_comb begin
    if (res.inv && !res.ovr)
      assert (1'b0) else $error("AST_INV_WITHOUT_OVR"); // R7
    if (res.ovr && !(&res.val[EXP_MSB:EXP_LSB] && res.val[QUIET_B]))
      assert (1'b0) else $error("AST_OVR_NOT_QUIET"); // R3
    if (!a_nan && !b_nan && !dp_inv && (res.ovr || res.val != '0))
      assert (1'b0) else $error("AST_CLEAN_NO_OVR"); // R8
  end
endmodule

// File: rtl/nanres_top.sv
module nanres_top
  import nanres_pkg::*;
#(
  parameter int LANES   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     one_op,
  input  logic [LANES*LANE_W-1:0]  src1,
  input  logic [LANES*LANE_W-1:0]  src2,
  input  logic [LANES-1:0]         dp_invalid,
  output logic                     out_valid,
  output logic [LANES-1:0]         ovr_valid,
  output logic [LANES*LANE_W-1:0]  ovr_value,
  output logic [LANES-1:0]         inv_flag
);
  localparam int DW = LANES * LANE_W;

  logic [LANES-1:0] ovr_d, inv_d;
  logic [DW-1:0]    val_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_res_t r;
    nanres_lane u_lane (
      .a      (src1[g*LANE_W +: LANE_W]),
      .b      (src2[g*LANE_W +: LANE_W]),
      .dp_inv (dp_invalid[g]),
      .one_op (one_op),
      .res    (r)
    );
    assign ovr_d[g]                 = r.ovr;
    assign inv_d[g]                 = r.inv;
    assign val_d[g*LANE_W +: LANE_W] = r.val;
  end

  if (REG_OUT) begin : g_reg
    logic             vld_q;
    logic [LANES-1:0] ovr_q, inv_q;
    logic [DW-1:0]    val_q;
    logic [LANES-1:0] ovr_n, inv_n;
    logic [DW-1:0]    val_n;
    logic             cap_en;

    always_comb begin
      cap_en = in_valid;
      ovr_n  = cap_en ? ovr_d : ovr_q;
      inv_n  = cap_en ? inv_d : inv_q;
      val_n  = cap_en ? val_d : val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        ovr_q <= '0;
        inv_q <= '0;
        val_q <= '0;
      end else begin
        vld_q <= in_valid;
        ovr_q <= ovr_n;
        inv_q <= inv_n;
        val_q <= val_n;
      end
    end

    assign out_valid = vld_q;
    assign ovr_valid = ovr_q;
    assign inv_flag  = inv_q;
    assign ovr_value = val_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid) else $error("AST_VALID_FOLLOWS"); // R9
    AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid) else $error("AST_IDLE_DROPS"); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(ovr_value) && $stable(ovr_valid) && $stable(inv_flag))
      else $error("AST_IDLE_HOLDS"); // R9
    AST_DPINV_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (dp_invalid != '0) |=> (inv_flag & $past(dp_invalid)) == $past(dp_invalid))
      else $error("AST_DPINV_FLAGS"); // R7
  end else begin : g_comb
    assign out_valid = in_valid;
    assign ovr_valid = ovr_d;
    assign inv_flag  = inv_d;
    assign ovr_value = val_d;
  end
endmodule

// File: tb/test_nanres_top.sv
module test_nanres_top;
  import nanres_pkg::*;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         one_op;
  logic [127:0] src1, src2;
  logic [3:0]   dp_invalid;
  logic         out_valid;
  logic [3:0]   ovr_valid, inv_flag;
  logic [127:0] ovr_value;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [3:0]   ovr;
    logic [3:0]   inv;
    logic [127:0] val;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  last_seen;
  bit    have_last = 0;

  always #5 clk = ~clk;

  nanres_top i_nanres_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .one_op(one_op),
    .src1(src1), .src2(src2), .dp_invalid(dp_invalid),
    .out_valid(out_valid), .ovr_valid(ovr_valid),
    .ovr_value(ovr_value), .inv_flag(inv_flag)
  );

  // Reference model written from the requirements
  function automatic bit m_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic bit m_snan(input logic [31:0] x);
    return m_nan(x) && !x[22];
  endfunction

  function automatic exp_t model(input logic [127:0] s1, input logic [127:0] s2,
                                 input logic [3:0] dpi, input logic op1);
    exp_t e;
    e = '0;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] a, b;
      bit an, bn, as, bs;
      a  = s1[i*32 +: 32];
      b  = s2[i*32 +: 32];
      an = m_nan(a);
      as = m_snan(a);
      bn = op1 ? 1'b0 : m_nan(b);
      bs = op1 ? 1'b0 : m_snan(b);
      if (an) begin
        e.ovr[i] = 1; e.val[i*32 +: 32] = a | 32'h0040_0000;
      end else if (bn) begin
        e.ovr[i] = 1; e.val[i*32 +: 32] = b | 32'h0040_0000;
      end else if (dpi[i]) begin
        e.ovr[i] = 1; e.val[i*32 +: 32] = 32'hFFC0_0000;
      end
      e.inv[i] = as || bs || dpi[i];
    end
    return e;
  endfunction

  task automatic drive(input string tag, input logic [127:0] s1, input logic [127:0] s2,
                       input logic [3:0] dpi, input logic op1);
    @(negedge clk);
    src1 = s1; src2 = s2; dp_invalid = dpi; one_op = op1; in_valid = 1'b1;
    exp_q.push_back(model(s1, s2, dpi, op1));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src1 = {4{32'h7F80_0001}}; src2 = {4{32'h7F80_0001}}; dp_invalid = 4'hF;
    end
  endtask

  // Monitor: samples at negedge, before the driver changes inputs in the same slot
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        exp_t e;
        exp_t got;
        string t;
        got = {ovr_valid, inv_flag, ovr_value};
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected out_valid: got %h expected none", got);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (got !== e) begin
            errors++;
            $display("FAIL %s: got ovr=%h inv=%h val=%h expected ovr=%h inv=%h val=%h",
                     t, got.ovr, got.inv, got.val, e.ovr, e.inv, e.val);
          end
        end
        last_seen = got; have_last = 1;
      end else if (rst_n && have_last) begin
        checks++;
        if ({ovr_valid, inv_flag, ovr_value} !== last_seen) begin
          errors++;
          $display("FAIL R9 hold while idle: got %h expected %h",
                   {ovr_valid, inv_flag, ovr_value}, last_seen);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] SN  = 32'h7F80_0001; // signalling
  localparam logic [31:0] SNN = 32'hFFAB_CDEF; // negative signalling, rich payload
  localparam logic [31:0] QN  = 32'hFFC1_2345; // quiet
  localparam logic [31:0] QN2 = 32'h7FE0_0F0F; // quiet
  localparam logic [31:0] ONE = 32'h3F80_0000;
  localparam logic [31:0] INF = 32'h7F80_0000;
  localparam logic [31:0] NINF= 32'hFF80_0000;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; one_op = 1'b0;
    src1 = '0; src2 = '0; dp_invalid = '0;
    repeat (3) @(negedge clk);
    checks++; // R9 reset state
    if (out_valid !== 1'b0 || ovr_valid !== 4'h0 || inv_flag !== 4'h0 || ovr_value !== '0) begin
      errors++;
      $display("FAIL R9 reset: got v=%b ovr=%h inv=%h val=%h expected all zero",
               out_valid, ovr_valid, inv_flag, ovr_value);
    end
    rst_n = 1'b1;

    // R8: no NaN, no invalid; R1 infinities are not NaN
    drive("R8 clean", {ONE, INF, NINF, 32'h0}, {INF, ONE, 32'h1, NINF}, 4'h0, 1'b0);
    // R2: both NaN, source 1 wins, even quiet src1 vs signalling src2
    drive("R2 both NaN", {QN, SN, SNN, QN2}, {SN, QN, QN2, SNN}, 4'h0, 1'b0);
    // R3: single signalling NaN quieted, sign and payload kept
    drive("R3 single sNaN", {SNN, ONE, SN, INF}, {ONE, SNN, INF, SN}, 4'h0, 1'b0);
    // R4 and R7: single quiet NaN unchanged, no exception
    drive("R4 single qNaN", {QN, ONE, QN2, INF}, {ONE, QN, INF, QN2}, 4'h0, 1'b0);
    // R6: default NaN on datapath invalid
    drive("R6 default NaN", {INF, ONE, INF, 32'h0}, {NINF, 32'h0, INF, 32'h0}, 4'hB, 1'b0);
    // R5: one-operand mode ignores src2
    drive("R5 one-op", {SNN, QN, ONE, ONE}, {SN, SN, SN, QN}, 4'h0, 1'b1);
    drive("R5 one-op dpi", {ONE, INF, SN, QN}, {SN, SNN, QN, SN}, 4'h3, 1'b1);
    // R7: NaN plus datapath invalid still flags
    drive("R7 qNaN with dpi", {QN, QN, QN2, QN2}, {ONE, QN2, ONE, QN}, 4'h5, 1'b0);
    idle(3);
    // R10: lanes independent, mixed cases per lane
    drive("R10 mixed lanes", {SN, QN, ONE, ONE}, {ONE, ONE, ONE, SNN}, 4'h2, 1'b0);
    idle(1);
    for (int n = 0; n < 200; n++) begin
      logic [127:0] a, b;
      logic [31:0] pick [8];
      pick[0] = SN; pick[1] = SNN; pick[2] = QN; pick[3] = QN2;
      pick[4] = ONE; pick[5] = INF; pick[6] = NINF; pick[7] = $urandom;
      for (int l = 0; l < 4; l++) begin
        a[l*32 +: 32] = pick[$urandom_range(0, 7)];
        b[l*32 +: 32] = pick[$urandom_range(0, 7)];
      end
      drive("R10 random", a, b, 4'($urandom), 1'($urandom));
      if (n % 7 == 0) idle(2);
    end
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing results: got %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule